// File: doc/BRIEF.md
# Staggered DRAM Refresh Scheduler

This block keeps an asynchronous DRAM array with several RAS rows refreshed. A free-running interval counter, clocked by the system clock, decides when a refresh falls due. The block then raises a request to the memory controller and waits for a grant, so that normal accesses can be held off. Once granted, it runs a CAS-before-RAS refresh on every row. The start of each row's sequence is offset from the previous row's start by a programmable stagger, which spreads the supply current surge over several cycles. A stagger of zero refreshes all rows together.

All settings come from one 32-bit timing word written through a simple write strobe. A new word is held in a shadow register and becomes active only when the interval counter next reloads. A refresh that falls due while another is still waiting for its grant is remembered in one overflow bit, so pending work is never lost. A busy flag covers the whole multi-row sequence, including the final precharge.

Top module: `dram_rfsh_stagger`

## Requirements
- R1: After reset, ref_req and busy are 0 and every ras_n and cas_n bit is 1. The active word then holds interval 0x30D, stagger 7, refresh on and a two-cycle CAS setup, so the first ref_req rises 781 cycles after reset is released.
- R2: With refresh on and grants given promptly, consecutive rising edges of ref_req are exactly the active interval apart. The interval is cfg_data[30:20], counted in clock cycles.
- R3: An interval field of 0 behaves as an interval of 1: a refresh falls due every cycle.
- R4: A word written with cfg_wr is not used until the interval counter next reloads. The period already running completes with the old interval, and the refresh that follows the reload already uses the new stagger and setup.
- R5: When the active enable bit, cfg_data[16], is 0, no refresh falls due. ref_req stays 0, all strobes stay high and busy stays 0.
- R6: In each row's sequence, cas_n goes low first and ras_n follows after the setup time, which cfg_data[15] selects: 1 gives one cycle and 0 gives two.
- R7: Each row holds ras_n low for exactly 4 cycles while cas_n is low. Then both strobes of that row return high in the same cycle.
- R8: Row i starts its sequence i times the stagger after row 0. The stagger is cfg_data[19:17], 0 to 7 cycles, and a stagger of 0 starts all rows in the same cycle.
- R9: No strobe moves until a pending request is granted. If ref_req and ref_gnt are both high at a clock edge while no sequence runs, row 0's cas_n falls at the next edge.
- R10: A refresh that falls due while one is already pending is kept in a single overflow bit. ref_req stays high after the first grant, and further dues add nothing beyond that one bit.
- R11: busy rises together with row 0's cas_n falling. It stays high until the last row's 2-cycle precharge ends, which is (rows-1)*stagger + setup + 6 cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base of the interval counter |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_data | input | 32 | Timing word: [30:20] interval, [19:17] stagger, [16] enable, [15] short CAS setup |
| ref_gnt | input | 1 | Grant from the memory controller |
| ref_req | output | 1 | Refresh pending, waiting for grant |
| busy | output | 1 | Refresh sequence in progress |
| ras_n | output | NUM_ROWS | Active-low RAS strobe per row |
| cas_n | output | NUM_ROWS | Active-low CAS strobe per row |

## Verification
The hardest state to reach from the ports is a saturated overflow: a refresh pending, a second one remembered, and then no new dues while the backlog drains. The stimulus sets a short interval, withholds the grant across several periods, and then writes a word with refresh off, which becomes active at the next reload. Two grants then show that exactly one extra refresh was kept. Reload timing is checked by writing a new interval in the middle of a long default period. Randomised stagger, setup and interval words, together with directed zero and maximum staggers, exercise the per-row timing.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int IVAL_W  = 11;
  localparam int STG_W   = 3;
  localparam int STG_MAX = (1 << STG_W) - 1;

  typedef struct packed {
    logic [IVAL_W-1:0] ival;
    logic [STG_W-1:0]  stg;
    logic              en;
    logic              cas1;
  } rfsh_cfg_t;

  localparam logic [31:0] CFG_RST = {1'b0, 11'h30D, 3'd7, 1'b1, 1'b0, 15'd0};

  function automatic rfsh_cfg_t decode_cfg(input logic [31:0] w);
    rfsh_cfg_t c;
    c.ival = w[30:20];
    c.stg  = w[19:17];
    c.en   = w[16];
    c.cas1 = w[15];
    return c;
  endfunction

  // zero interval is promoted to one
  function automatic logic [IVAL_W-1:0] eff_ival(input logic [IVAL_W-1:0] v);
    return (v == '0) ? IVAL_W'(1) : v;
  endfunction

  function automatic logic [1:0] setup_len(input logic cas1);
    return cas1 ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_data,
  output rfsh_cfg_t   act_cfg,
  output logic        due
);

  logic [31:0]       shadow;
  logic [IVAL_W-1:0] cnt;
  logic [IVAL_W-1:0] lim;

  assign lim = eff_ival(act_cfg.ival) - IVAL_W'(1);
  assign due = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= CFG_RST;
      act_cfg <= decode_cfg(CFG_RST);
      cnt     <= '0;
    end else begin
      if (cfg_wr) shadow <= cfg_data;
      if (due) begin
        cnt     <= '0;
        act_cfg <= decode_cfg(shadow);
      end else begin
        cnt <= cnt + IVAL_W'(1);
      end
    end
  end

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic en,
  input  logic seq_idle,
  input  logic ref_gnt,
  output logic ref_req,
  output logic start
);

  logic pend, ovf, due_en;

  assign due_en  = due & en;
  assign ref_req = pend;
  assign start   = pend & ref_gnt & seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else if (start) begin
      pend <= ovf | due_en;
      ovf  <= ovf & due_en;
    end else if (due_en) begin
      if (pend) ovf  <= 1'b1;
      else      pend <= 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_launcher.sv
module rfsh_launcher
  import rfsh_pkg::*;
#(
  parameter int NUM_ROWS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [STG_W-1:0]    stg,
  input  logic                cas1,
  input  logic                last_done,
  output logic                run,
  output logic                cas1_l,
  output logic [NUM_ROWS-1:0] launch
);

  localparam int EMAX = (NUM_ROWS - 1) * STG_MAX + 1;
  localparam int EL_W = $clog2(EMAX + 1);

  logic [EL_W-1:0]  e;
  logic [STG_W-1:0] stg_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      e      <= '0;
      stg_l  <= '0;
      cas1_l <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      e      <= '0;
      stg_l  <= stg;
      cas1_l <= cas1;
    end else if (run) begin
      if (last_done) run <= 1'b0;
      if (e != EL_W'(EMAX)) e <= e + EL_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_launch
    logic [EL_W-1:0] ofs;
    assign ofs       = EL_W'(i) * EL_W'(stg_l);
    assign launch[i] = run & (e == ofs);
  end

endmodule

// File: rtl/rfsh_row.sv
module rfsh_row #(
  parameter int RAS_LOW = 4,
  parameter int PRECHG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [1:0] setup_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       active,
  output logic       done
);

  localparam int PH_W = $clog2(2 + RAS_LOW + PRECHG + 1);

  logic [PH_W-1:0] ph, s_w, ras_end, last;

  assign s_w     = PH_W'(setup_n);
  assign ras_end = s_w + PH_W'(RAS_LOW);
  assign last    = ras_end + PH_W'(PRECHG);

  always_ff @(posedge clk) begin
    if (!rst_n)              ph <= '0;
    else if (ph == '0)       ph <= launch ? PH_W'(1) : '0;
    else if (ph == last)     ph <= '0;
    else                     ph <= ph + PH_W'(1);
  end

  assign active = (ph != '0);
  assign done   = (ph == last);
  assign cas_n  = !(active && (ph <= ras_end));
  assign ras_n  = !((ph > s_w) && (ph <= ras_end));

endmodule

// File: rtl/dram_rfsh_stagger.sv
module dram_rfsh_stagger
  import rfsh_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int RAS_LOW  = 4,
  parameter int PRECHG   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [31:0]         cfg_data,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                busy,
  output logic [NUM_ROWS-1:0] ras_n,
  output logic [NUM_ROWS-1:0] cas_n
);

  rfsh_cfg_t           act_cfg;
  logic                due_pulse;
  logic                seq_start;
  logic                seq_run;
  logic                cas1_l;
  logic [NUM_ROWS-1:0] launch;
  logic [NUM_ROWS-1:0] row_active;
  logic [NUM_ROWS-1:0] row_done;
  logic [1:0]          setup_n;

  rfsh_interval u_ival (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .act_cfg  (act_cfg),
    .due      (due_pulse)
  );

  rfsh_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .due      (due_pulse),
    .en       (act_cfg.en),
    .seq_idle (!seq_run),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .start    (seq_start)
  );

  rfsh_launcher #(.NUM_ROWS(NUM_ROWS)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .stg       (act_cfg.stg),
    .cas1      (act_cfg.cas1),
    .last_done (row_done[NUM_ROWS-1]),
    .run       (seq_run),
    .cas1_l    (cas1_l),
    .launch    (launch)
  );

  assign setup_n = setup_len(cas1_l);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    rfsh_row #(.RAS_LOW(RAS_LOW), .PRECHG(PRECHG)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch[i]),
      .setup_n (setup_n),
      .ras_n   (ras_n[i]),
      .cas_n   (cas_n[i]),
      .active  (row_active[i]),
      .done    (row_done[i])
    );
  end

  assign busy = |row_active;

endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ref_req,
  input logic         ref_gnt,
  input logic         busy,
  input logic         seq_start,
  input logic [N-1:0] ras_n,
  input logic [N-1:0] cas_n
);

  // R9
  gnt_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && ref_gnt, 2));

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !seq_start) |=> ref_req);

  // R11
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> busy);

  for (genvar i = 0; i < N; i++) begin : g_row_chk
    // R6
    ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n[i] |-> !cas_n[i]);
    // R6
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n[i]) |-> $past(!cas_n[i]));
    // R7
    joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n[i]) |-> $rose(cas_n[i]));
  end

endmodule

bind dram_rfsh_stagger rfsh_chk #(.N(NUM_ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_req   (ref_req),
  .ref_gnt   (ref_gnt),
  .busy      (busy),
  .seq_start (seq_start),
  .ras_n     (ras_n),
  .cas_n     (cas_n)
);

// File: tb/dram_rfsh_stagger_tb.sv
`timescale 1ns/1ps
module dram_rfsh_stagger_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n, cfg_wr, ref_gnt;
  logic [31:0]  cfg_data;
  logic         ref_req, busy;
  logic [N-1:0] ras_n, cas_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int last_rise = 0, prev_rise = 0;
  logic req_q = 1'b0;

  always #2.5 clk = ~clk;

  dram_rfsh_stagger #(.NUM_ROWS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  always @(posedge clk) if (rst_n === 1'b1) cyc++;

  always @(negedge clk) begin
    if (ref_req === 1'b1 && req_q !== 1'b1) begin
      prev_rise = last_rise;
      last_rise = cyc;
    end
    req_q = ref_req;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_cas(input int k, input int stg, input int s);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      int ph = k - i * stg;
      v[i] = !(ph >= 1 && ph <= s + 4);
    end
    return v;
  endfunction

  function automatic logic [N-1:0] exp_ras(input int k, input int stg, input int s);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      int ph = k - i * stg;
      v[i] = !(ph >= s + 1 && ph <= s + 4);
    end
    return v;
  endfunction

  function automatic logic exp_busy(input int k, input int stg, input int s);
    return (k >= 1) && (k <= (N - 1) * stg + s + 6);
  endfunction

  task automatic wcfg(input int ival, input int stg, input bit en, input bit cas1);
    @(negedge clk);
    cfg_data = {1'b0, 11'(ival), 3'(stg), en, cas1, 15'd0};
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  // grant one pending refresh; optionally check the strobe waveform
  task automatic serve(input bit do_chk, input int stg, input int s);
    while (ref_req !== 1'b1) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    if (do_chk)
      chk(cas_n == '1 && ras_n == '1, "R9", "strobes idle at grant edge", int'(cas_n), 15);
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      if (do_chk) begin
        // R6 R7 R8
        chk(cas_n == exp_cas(k, stg, s), "R6", $sformatf("cas_n k=%0d", k),
            int'(cas_n), int'(exp_cas(k, stg, s)));
        chk(ras_n == exp_ras(k, stg, s), "R7", $sformatf("ras_n k=%0d", k),
            int'(ras_n), int'(exp_ras(k, stg, s)));
        chk(busy == exp_busy(k, stg, s), "R11", $sformatf("busy k=%0d", k),
            int'(busy), int'(exp_busy(k, stg, s)));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cfg_wr = 1'b0; ref_gnt = 1'b0; cfg_data = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(ref_req == 1'b0, "R1", "ref_req after reset", int'(ref_req), 0);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(ras_n == '1 && cas_n == '1, "R1", "strobes after reset", int'(ras_n), 15);

    // R1 default timing, R8 stagger 7
    serve(1'b1, 7, 2);
    chk(last_rise == 781, "R1", "first request cycle", last_rise, 781);

    // R4 write mid-period: old period completes, then new word applies
    wcfg(100, 3, 1'b1, 1'b1);
    serve(1'b1, 3, 1);
    chk(last_rise == 1562, "R4", "request with old interval", last_rise, 1562);
    serve(1'b1, 3, 1);
    chk(last_rise == 1662, "R4", "request with new interval", last_rise, 1662);
    chk(last_rise - prev_rise == 100, "R2", "period 100", last_rise - prev_rise, 100);

    // R2 R6 R8 randomised words
    for (int r = 0; r < 4; r++) begin
      int iv = 60 + int'($urandom % 140);
      int sg = int'($urandom % 8);
      int c1 = int'($urandom % 2);
      wcfg(iv, sg, 1'b1, c1[0]);
      serve(1'b0, 0, 0);
      serve(1'b0, 0, 0);
      serve(1'b1, sg, c1 ? 1 : 2);
      serve(1'b1, sg, c1 ? 1 : 2);
      chk(last_rise - prev_rise == iv, "R2", "random period", last_rise - prev_rise, iv);
    end

    // R8 stagger 0: all rows together
    wcfg(80, 0, 1'b1, 1'b0);
    serve(1'b0, 0, 0);
    serve(1'b0, 0, 0);
    serve(1'b1, 0, 2);
    serve(1'b1, 0, 2);
    chk(last_rise - prev_rise == 80, "R2", "period 80", last_rise - prev_rise, 80);

    // R3 zero interval acts as one
    wcfg(0, 0, 1'b1, 1'b1);
    serve(1'b0, 0, 0);
    serve(1'b0, 0, 0);
    for (int r = 0; r < 3; r++) begin
      serve(1'b1, 0, 1);
      chk(ref_req == 1'b1, "R3", "request renewed every cycle", int'(ref_req), 1);
    end

    // R10 overflow kept in one bit
    wcfg(10, 0, 1'b1, 1'b1);
    serve(1'b0, 0, 0);
    serve(1'b0, 0, 0);
    for (int r = 0; r < 4; r++) begin
      repeat (10) @(negedge clk);
      chk(cas_n == '1 && busy == 1'b0, "R9", "no strobe without grant", int'(cas_n), 15);
    end
    wcfg(10, 0, 1'b0, 1'b1);
    repeat (25) @(negedge clk);
    chk(ref_req == 1'b1, "R10", "request pending before grant", int'(ref_req), 1);
    serve(1'b1, 0, 1);
    chk(ref_req == 1'b1, "R10", "overflow survives first grant", int'(ref_req), 1);
    serve(1'b0, 0, 0);
    chk(ref_req == 1'b0, "R10", "only one extra refresh kept", int'(ref_req), 0);

    // R5 refresh disabled
    for (int r = 0; r < 10; r++) begin
      repeat (10) @(negedge clk);
      chk(ref_req == 1'b0 && busy == 1'b0 && ras_n == '1 && cas_n == '1,
          "R5", "idle while disabled", int'(ref_req), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule